// File: doc/BRIEF.md
# Up-Counting Timer with Selectable Trigger Output

The block is an up-counting timer for a large chip's peripheral fabric. A prescaler divides the clock, and the main counter steps once per prescaler period from zero to a reload value, then wraps to zero. Each wrap is an update event. Four compare channels watch the counter. Each channel produces a level reference output for edge-aligned PWM and a one-cycle compare pulse that sets a sticky flag.

A three-bit trigger-select field picks which internal signal drives a single trigger line toward a slave timer or an ADC. The choices are:
- a software-forced update,
- the run bit,
- the update event,
- the channel-0 compare pulse,
- one of the four channel references.

Prescaler and reload values are held in a buffer stage. They move into the active stage on an update event or on a software-forced update, so a running period is never cut short.

Software reaches the block through a flat write port and a combinational read port, both word-addressed.

Top module: `trig_timer`

## Requirements
- R1: While the run bit (CTRL bit 0, address 0) is set, the counter advances by one every PRESC+1 clocks, where PRESC is the active prescaler value (address 2).
- R2: The counter, read at address 8, runs from 0 to the active reload value and then wraps to 0. The update output `upd_o` is high in the single clock in which the counter sits at the reload value and the prescaler is at its last step.
- R3: The trigger-select field CTRL[6:4] drives `trgo_o` as follows:
  - 0 selects the forced-update pulse.
  - 1 selects the run bit.
  - 2 selects `upd_o`.
  - 3 selects the channel-0 compare pulse.
  - 4, 5, 6 and 7 select the reference outputs of channels 0, 1, 2 and 3.
- R4: The compare pulse of channel i lasts one clock. It occurs in the first prescaler step in which the counter equals compare register i (address 4+i) while running. Status bit i (address 9) sets on the following edge. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R5: Reference output `oc_ref_o[i]` is high exactly while the counter is below compare register i.
- R6: With the reload buffer bit (CTRL bit 1) set, a new reload value takes effect only at the next update event. With that bit clear, the new value takes effect at once.
- R7: Writing 1 to bit 0 of address 1 raises a forced-update pulse for one clock, which also appears on `upd_o`. On the next edge the counter and prescaler clear, and the buffered prescaler and reload values become active. Address 1 always reads 0.
- R8: While the run bit is clear, the counter holds its value. In that state `upd_o` and the update-mode trigger pulse only for a forced update.
- R9: Unimplemented bits and unmapped addresses read 0. Writing all ones reads back as 0xFFFF at address 3 and as 0x73 at address 0.
- R10: After reset, every register, the counter, the flags and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read word address |
| rd_data | output | DW | Combinational read data |
| upd_o | output | 1 | Update event pulse |
| trgo_o | output | 1 | Selected trigger output |
| oc_ref_o | output | NCH | Per-channel PWM reference |
| cmp_flag_o | output | NCH | Sticky compare flags |

## Verification
The properties assume a compare or update decision is made only from register state, and that the software update request and the run bit are the only means of moving the counter. They further assume the counter never starts above the reload value. The stimulus keeps within this by loading the prescaler and reload values before each forced update. Each sweep is then started from that forced update, so the counter always begins at zero below the reload value. Reload values are lowered only in the dedicated buffered and unbuffered scenarios, where the counter is still at or below the new limit.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
   typedef enum logic [2:0] {
      TRG_FORCE     = 3'd0,
      TRG_RUN       = 3'd1,
      TRG_UPDATE    = 3'd2,
      TRG_CMP_PULSE = 3'd3,
      TRG_REF0      = 3'd4,
      TRG_REF1      = 3'd5,
      TRG_REF2      = 3'd6,
      TRG_REF3      = 3'd7
   } trg_sel_e;

   localparam int unsigned ADDR_CTRL   = 0;
   localparam int unsigned ADDR_EVGEN  = 1;
   localparam int unsigned ADDR_PRESC  = 2;
   localparam int unsigned ADDR_RELOAD = 3;
   localparam int unsigned ADDR_CMP0   = 4;
   localparam int unsigned ADDR_COUNT  = 8;
   localparam int unsigned ADDR_STATUS = 9;

   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_BUF_BIT = 1;
   localparam int unsigned CTRL_SEL_LSB = 4;
endpackage

// File: rtl/trig_timer_regs.sv
module trig_timer_regs import trig_timer_pkg::*; #(
   parameter int unsigned DW    = 32,
   parameter int unsigned AW    = 4,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PSC_W = 16,
   parameter int unsigned NCH   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_addr,
   input  logic [DW-1:0]              wr_data,
   input  logic [AW-1:0]              rd_addr,
   output logic [DW-1:0]              rd_data,
   input  logic [CNT_W-1:0]           cnt,
   input  logic [NCH-1:0]             flags,
   output logic                       run_q,
   output logic                       buf_q,
   output trg_sel_e                   sel_q,
   output logic [PSC_W-1:0]           psc_q,
   output logic [CNT_W-1:0]           arr_q,
   output logic [NCH-1:0][CNT_W-1:0]  cmp_q,
   output logic                       ug_q,
   output logic [NCH-1:0]             flag_clr
);
   localparam int unsigned SEL_MSB = CTRL_SEL_LSB + 2;

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         buf_q <= 1'b0;
         sel_q <= TRG_FORCE;
         psc_q <= '0;
         arr_q <= '0;
         cmp_q <= '0;
         ug_q  <= 1'b0;
      end else begin
         ug_q <= wr_en && (wr_addr == AW'(ADDR_EVGEN)) && wr_data[0];
         if (wr_en) begin
            case (wr_addr)
               AW'(ADDR_CTRL): begin
                  run_q <= wr_data[CTRL_RUN_BIT];
                  buf_q <= wr_data[CTRL_BUF_BIT];
                  sel_q <= trg_sel_e'(wr_data[SEL_MSB:CTRL_SEL_LSB]);
               end
               AW'(ADDR_PRESC):  psc_q <= wr_data[PSC_W-1:0];
               AW'(ADDR_RELOAD): arr_q <= wr_data[CNT_W-1:0];
               default: ;
            endcase
            for (int i = 0; i < NCH; i++) begin
               if (wr_addr == AW'(ADDR_CMP0 + i)) cmp_q[i] <= wr_data[CNT_W-1:0];
            end
         end
      end
   end

   assign flag_clr = (wr_en && (wr_addr == AW'(ADDR_STATUS))) ? wr_data[NCH-1:0] : '0;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         AW'(ADDR_CTRL): begin
            rd_data[CTRL_RUN_BIT]             = run_q;
            rd_data[CTRL_BUF_BIT]             = buf_q;
            rd_data[SEL_MSB:CTRL_SEL_LSB]     = sel_q;
         end
         AW'(ADDR_PRESC):  rd_data[PSC_W-1:0] = psc_q;
         AW'(ADDR_RELOAD): rd_data[CNT_W-1:0] = arr_q;
         AW'(ADDR_COUNT):  rd_data[CNT_W-1:0] = cnt;
         AW'(ADDR_STATUS): rd_data[NCH-1:0]   = flags;
         default: ;
      endcase
      for (int i = 0; i < NCH; i++) begin
         if (rd_addr == AW'(ADDR_CMP0 + i)) rd_data[CNT_W-1:0] = cmp_q[i];
      end
   end
endmodule

// File: rtl/trig_timer_core.sv
module trig_timer_core #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             buf_en,
   input  logic             ug,
   input  logic [PSC_W-1:0] psc_pre,
   input  logic [CNT_W-1:0] arr_pre,
   output logic [CNT_W-1:0] cnt_q,
   output logic [PSC_W-1:0] pcnt_q,
   output logic [PSC_W-1:0] psc_act_q,
   output logic             upd
);
   logic [CNT_W-1:0] arr_act_q;
   logic [CNT_W-1:0] arr_eff;
   logic             tick;
   logic             wrap;

   assign arr_eff = buf_en ? arr_act_q : arr_pre;
   assign tick    = run && (pcnt_q == psc_act_q);
   assign wrap    = tick && (cnt_q == arr_eff);
   assign upd     = ug || wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         pcnt_q    <= '0;
         psc_act_q <= '0;
         arr_act_q <= '0;
      end else if (ug) begin
         cnt_q     <= '0;
         pcnt_q    <= '0;
         psc_act_q <= psc_pre;
         arr_act_q <= arr_pre;
      end else if (run) begin
         if (tick) begin
            pcnt_q <= '0;
            if (wrap) begin
               cnt_q     <= '0;
               psc_act_q <= psc_pre;
               arr_act_q <= arr_pre;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end else begin
            pcnt_q <= pcnt_q + PSC_W'(1);
         end
      end
   end
endmodule

// File: rtl/trig_timer_chan.sv
module trig_timer_chan #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             run,
   input  logic             ug,
   input  logic             first_step,
   input  logic             clr,
   output logic             ref_o,
   output logic             hit_o,
   output logic             flag_o
);
   assign ref_o = cnt < cmp;
   assign hit_o = run && !ug && first_step && (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= (flag_o && !clr) || hit_o;
   end
endmodule

// File: rtl/trig_timer_trgsel.sv
module trig_timer_trgsel import trig_timer_pkg::*; #(
   parameter int unsigned NCH = 4
) (
   input  trg_sel_e       sel,
   input  logic           ug,
   input  logic           run,
   input  logic           upd,
   input  logic           hit0,
   input  logic [NCH-1:0] refs,
   output logic           trgo
);
   localparam int unsigned NREF = 4;
   logic [NREF-1:0] ref_pad;

   for (genvar i = 0; i < NREF; i++) begin : g_pad
      if (i < NCH) begin : g_have
         assign ref_pad[i] = refs[i];
      end else begin : g_none
         assign ref_pad[i] = 1'b0;
      end
   end

   always_comb begin
      case (sel)
         TRG_FORCE:     trgo = ug;
         TRG_RUN:       trgo = run;
         TRG_UPDATE:    trgo = upd;
         TRG_CMP_PULSE: trgo = hit0;
         default:       trgo = ref_pad[sel[1:0]];
      endcase
   end
endmodule

// File: rtl/trig_timer.sv
module trig_timer import trig_timer_pkg::*; #(
   parameter int unsigned DW    = 32,
   parameter int unsigned AW    = 4,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PSC_W = 16,
   parameter int unsigned NCH   = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [DW-1:0]  wr_data,
   input  logic [AW-1:0]  rd_addr,
   output logic [DW-1:0]  rd_data,
   output logic           upd_o,
   output logic           trgo_o,
   output logic [NCH-1:0] oc_ref_o,
   output logic [NCH-1:0] cmp_flag_o
);
   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("trig_timer: NCH must lie in 1..4");
   end
   if (CNT_W < 2 || CNT_W > DW || PSC_W < 1 || PSC_W > DW) begin : g_bad_width
      $error("trig_timer: counter and prescaler widths must fit the data bus");
   end
   if (AW < 4 || DW < 8) begin : g_bad_bus
      $error("trig_timer: address needs 4 bits and data 8 bits at least");
   end

   logic                      run_q;
   logic                      buf_q;
   trg_sel_e                  sel_q;
   logic [PSC_W-1:0]          psc_pre;
   logic [CNT_W-1:0]          arr_pre;
   logic [NCH-1:0][CNT_W-1:0] cmp_q;
   logic                      ug_q;
   logic [NCH-1:0]            flag_clr;
   logic [CNT_W-1:0]          cnt_q;
   logic [PSC_W-1:0]          pcnt_q;
   logic [PSC_W-1:0]          psc_act_q;
   logic [NCH-1:0]            hit_v;
   logic                      first_step;

   trig_timer_regs #(.DW(DW), .AW(AW), .CNT_W(CNT_W), .PSC_W(PSC_W), .NCH(NCH)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt_q), .flags(cmp_flag_o),
      .run_q(run_q), .buf_q(buf_q), .sel_q(sel_q), .psc_q(psc_pre), .arr_q(arr_pre),
      .cmp_q(cmp_q), .ug_q(ug_q), .flag_clr(flag_clr)
   );

   trig_timer_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_core (
      .clk(clk), .rst_n(rst_n), .run(run_q), .buf_en(buf_q), .ug(ug_q),
      .psc_pre(psc_pre), .arr_pre(arr_pre), .cnt_q(cnt_q), .pcnt_q(pcnt_q),
      .psc_act_q(psc_act_q), .upd(upd_o)
   );

   assign first_step = (pcnt_q == '0);

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      trig_timer_chan #(.CNT_W(CNT_W)) i_chan (
         .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .cmp(cmp_q[i]), .run(run_q), .ug(ug_q),
         .first_step(first_step), .clr(flag_clr[i]), .ref_o(oc_ref_o[i]),
         .hit_o(hit_v[i]), .flag_o(cmp_flag_o[i])
      );
   end

   trig_timer_trgsel #(.NCH(NCH)) i_trgsel (
      .sel(sel_q), .ug(ug_q), .run(run_q), .upd(upd_o), .hit0(hit_v[0]),
      .refs(oc_ref_o), .trgo(trgo_o)
   );
endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PSC_W = 16,
   parameter int unsigned NCH   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             ug,
   input logic             upd,
   input logic [CNT_W-1:0] cnt,
   input logic [PSC_W-1:0] pcnt,
   input logic [PSC_W-1:0] psc_act,
   input logic [NCH-1:0]   hit,
   input logic [NCH-1:0]   flag
);
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ug) |=> $stable(cnt));

   // R1
   prescale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ug && (pcnt != psc_act)) |=> $stable(cnt));

   // R2
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (cnt == '0));

   // R7
   force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ug |=> ((cnt == '0) && (pcnt == '0)));

   for (genvar i = 0; i < NCH; i++) begin : g_flag
      // R4
      flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit[i] |=> flag[i]);
   end
endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W), .NCH(NCH)) i_trig_timer_chk (
   .clk(clk), .rst_n(rst_n), .run(run_q), .ug(ug_q), .upd(upd_o), .cnt(cnt_q),
   .pcnt(pcnt_q), .psc_act(psc_act_q), .hit(hit_v), .flag(cmp_flag_o)
);

// File: tb/test_trig_timer.sv
module test_trig_timer;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  wr_addr = '0;
   logic [DW-1:0]  wr_data = '0;
   logic [AW-1:0]  rd_addr = '0;
   logic [DW-1:0]  rd_data;
   logic           upd_o;
   logic           trgo_o;
   logic [NCH-1:0] oc_ref_o;
   logic [NCH-1:0] cmp_flag_o;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   trig_timer #(.DW(DW), .AW(AW), .CNT_W(16), .PSC_W(16), .NCH(NCH)) i_trig_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .upd_o(upd_o), .trgo_o(trgo_o),
      .oc_ref_o(oc_ref_o), .cmp_flag_o(cmp_flag_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = AW'(a);
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_addr = AW'(a);
      #1;
      d = rd_data;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] c0;
      int ep, ec, eu, et, eh;
      logic [3:0] eref;
      int exp_seq[7];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      for (int a = 0; a < 10; a++) begin
         rd(a, d);
         check("R10 register", d, 0);
      end
      check("R10 upd", upd_o, 0);
      check("R10 trgo", trgo_o, 0);
      check("R10 ref", oc_ref_o, 0);
      check("R10 flags", cmp_flag_o, 0);

      // R9: unimplemented bits read zero
      wr(3, 32'hFFFF_FFFF);
      rd(3, d);
      check("R9 reload all ones", d, 32'h0000_FFFF);
      wr(0, 32'hFFFF_FFFF);
      rd(0, d);
      check("R9 ctrl all ones", d, 32'h73);
      wr(0, 0);
      wr(1, 32'hFFFF_FFFF);
      rd(1, d);
      check("R7 R9 evgen reads zero", d, 0);
      rd(12, d);
      check("R9 unmapped", d, 0);

      for (int i = 0; i < NCH; i++) wr(4 + i, 32'(i + 1));

      // R1 R2 R3 R5: sweep trigger modes, prescaler and reload values
      for (int m = 0; m < 8; m++) begin
         for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < 5; a++) begin
               wr(2, 32'(p));
               wr(3, 32'(a));
               wr(0, 32'(3 | (m << 4)));
               wr(1, 1);
               check("R7 forced update pulse", upd_o, 1);
               if (m == 0) check("R3 mode force", trgo_o, 1);
               if (m == 1) check("R3 mode run", trgo_o, 1);
               if (m == 2) check("R3 mode update on force", trgo_o, 1);
               for (int n = 0; n < 2 * (p + 1) * (a + 1) + 1; n++) begin
                  @(negedge clk);
                  ep = n % (p + 1);
                  ec = (n / (p + 1)) % (a + 1);
                  rd(8, d);
                  check("R1 R2 count", d, 32'(ec));
                  eu = (ep == p && ec == a) ? 1 : 0;
                  check("R2 update", upd_o, 32'(eu));
                  for (int i = 0; i < 4; i++) eref[i] = (ec < i + 1);
                  check("R5 refs", oc_ref_o, eref);
                  eh = (ep == 0 && ec == 1) ? 1 : 0;
                  case (m)
                     0: et = 0;
                     1: et = 1;
                     2: et = eu;
                     3: et = eh;
                     default: et = eref[m - 4];
                  endcase
                  check("R3 trigger", trgo_o, 32'(et));
               end
            end
         end
      end

      // R6: buffered reload takes effect at the update
      wr(2, 0);
      wr(3, 3);
      wr(0, 32'h23);
      wr(1, 1);
      wr(3, 1);
      exp_seq = '{1, 2, 3, 0, 1, 0, 1};
      for (int k = 0; k < 7; k++) begin
         if (k > 0) @(negedge clk);
         rd(8, d);
         check("R6 buffered reload", d, 32'(exp_seq[k]));
      end

      // R6: unbuffered reload takes effect at once
      wr(3, 3);
      wr(0, 32'h21);
      wr(1, 1);
      wr(3, 1);
      exp_seq = '{1, 0, 1, 0, 1, 0, 1};
      for (int k = 0; k < 7; k++) begin
         if (k > 0) @(negedge clk);
         rd(8, d);
         check("R6 direct reload", d, 32'(exp_seq[k]));
      end

      // R8: stopped counter holds, update only by force
      wr(3, 5);
      wr(0, 32'h20);
      rd(8, c0);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         rd(8, d);
         check("R8 hold count", d, c0);
         check("R8 no update while stopped", upd_o, 0);
         check("R8 trigger quiet", trgo_o, 0);
      end
      wr(1, 1);
      check("R8 forced trigger", trgo_o, 1);
      check("R7 forced update", upd_o, 1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         rd(8, d);
         check("R7 R8 count cleared and held", d, 0);
         check("R7 pulse self clears", trgo_o, 0);
      end

      // R4: compare pulse on trigger and sticky flag
      wr(2, 1);
      wr(3, 4);
      wr(4, 2);
      wr(9, 32'hF);
      check("R4 flags cleared", cmp_flag_o[0], 0);
      wr(1, 1);
      wr(0, 32'h31);
      for (int n = 0; n < 8; n++) begin
         if (n > 0) @(negedge clk);
         check("R3 R4 compare pulse", trgo_o, (n == 4) ? 1 : 0);
         check("R4 flag", cmp_flag_o[0], (n >= 5) ? 1 : 0);
      end
      wr(0, 0);
      rd(9, d);
      check("R4 status read", d[0], 1);
      wr(9, 0);
      rd(9, d);
      check("R4 write zero keeps flag", d[0], 1);
      wr(9, 1);
      rd(9, d);
      check("R4 write one clears flag", d[0], 0);

      summary();
      $finish;
   end
endmodule